// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Flags

This block recovers 8-bit characters from an asynchronous serial line. The line is sampled on an oversample tick supplied from outside, 16 ticks per bit period by default. Each bit is decided by a majority vote of the three ticks at the centre of the bit. A falling edge on an idle line opens a candidate start bit. The candidate is confirmed or dropped by the vote taken at the middle of that bit. The frame has one start bit, eight data bits sent least significant bit first, one stop bit and no parity.

A completed character is placed in a data register and a receive-full indication is raised. A status register reports four things: receive-full and three sticky error conditions. Overrun means a character arrived while the previous one was still unread. Noise means some bit vote was not unanimous. Framing means the stop bit was sampled low. Software reads the status register through one strobe and the data register through another. An error condition is cleared only when a status read sees it set and a data read follows. A data read on its own empties the register but leaves the error conditions in place.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `status_o` is 0, `data_o` is 0x00 and `rx_full_o` is 0.
- R2: A well-formed frame (start 0, eight data bits LSB first, stop 1) that arrives while the register is empty puts the character on `data_o` and sets `rx_full_o`, which is also `status_o[3]`. A data read clears `rx_full_o`.
- R3: Each bit value is the majority of samples 7, 8 and 9 of the bit period, where sample 0 is the first low sample of the start bit. A single inverted sample does not change the received value.
- R4: The noise flag `status_o[1]` sets when any vote in a frame is not unanimous. A disturbance at a sample outside positions 7 to 9 does not set it.
- R5: The framing flag `status_o[0]` sets when the stop bit votes 0. The character is still delivered.
- R6: A low pulse that ends before sample 7 of the start bit is dropped. No character is delivered and the next frame is received normally.
- R7: If a character completes while `rx_full_o` is 1, the overrun flag `status_o[2]` sets, the new character is discarded and `data_o` keeps the unread character.
- R8: A status read that sees an error flag set, followed by a data read, clears that flag.
- R9: A data read with no status read before it clears `rx_full_o` and leaves every error flag set.
- R10: An error flag that sets after the status read is not cleared by the data read that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample tick, OVS pulses per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| status_o | output | 4 | {receive-full, overrun, noise, framing} |
| data_o | output | 8 | Received character |
| rx_full_o | output | 1 | Unread character present |

## Verification
All 256 character values are sent as clean frames. This shows that every data bit lands in the right position and that a clean frame raises no flag. A single inverted sample is then walked across all 16 positions of one data bit. This separates the three voting samples, which must raise noise without corrupting the value, from the other positions, which must change nothing. Frames with a low stop bit, a short false start, and back-to-back unread characters cover framing, false-start rejection and overrun. Read sequences are then varied: data read alone, status then data, and a flag that appears between the two reads. These show which flags each read order clears.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } srx_state_e;

   typedef struct packed {
      logic overrun;
      logic noise;
      logic framing;
   } srx_err_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else if (STAGES == 1) begin
               chain_q[0] <= d_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              line_i,
   output logic              done_o,
   output logic [DATA_W-1:0] char_o,
   output logic              noise_o,
   output logic              frame_err_o
);

   localparam int SUB_W = $clog2(OVS);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int S_MID = OVS / 2;
   localparam int S_LO  = S_MID - 1;
   localparam int S_HI  = S_MID + 1;

   srx_state_e        state_q;
   logic [SUB_W-1:0]  sub_q;
   logic [CNT_W-1:0]  bit_q;
   logic [1:0]        win_q;
   logic              prev_q;
   logic              noise_acc_q;
   logic [DATA_W-1:0] shreg_q;

   logic eval, vote, unan, bit_end;

   assign eval    = tick_i && (state_q != ST_IDLE) && (sub_q == SUB_W'(S_HI));
   assign bit_end = tick_i && (sub_q == SUB_W'(OVS - 1));
   assign vote    = (win_q[1] & win_q[0]) | (win_q[1] & line_i) | (win_q[0] & line_i);
   assign unan    = (win_q[1] == win_q[0]) && (win_q[0] == line_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sub_q       <= '0;
         bit_q       <= '0;
         win_q       <= 2'b11;
         prev_q      <= 1'b1;
         noise_acc_q <= 1'b0;
         shreg_q     <= '0;
         done_o      <= 1'b0;
         char_o      <= '0;
         noise_o     <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) prev_q <= line_i;
         if (state_q == ST_IDLE) begin
            if (tick_i && prev_q && !line_i) begin
               state_q     <= ST_START;
               sub_q       <= SUB_W'(1);
               noise_acc_q <= 1'b0;
            end
         end else if (tick_i) begin
            sub_q <= bit_end ? '0 : sub_q + 1'b1;
            if (sub_q == SUB_W'(S_LO)) win_q[1] <= line_i;
            if (sub_q == SUB_W'(S_MID)) win_q[0] <= line_i;
            if (eval) begin
               noise_acc_q <= noise_acc_q | ~unan;
               case (state_q)
                  ST_START: if (vote) state_q <= ST_IDLE;
                  ST_DATA:  shreg_q <= {vote, shreg_q[DATA_W-1:1]};
                  ST_STOP: begin
                     done_o      <= 1'b1;
                     char_o      <= shreg_q;
                     noise_o     <= noise_acc_q | ~unan;
                     frame_err_o <= ~vote;
                     state_q     <= ST_IDLE;
                  end
                  default: ;
               endcase
            end
            if (bit_end) begin
               if (state_q == ST_START) begin
                  state_q <= ST_DATA;
                  bit_q   <= '0;
               end else if (state_q == ST_DATA) begin
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == CNT_W'(DATA_W - 1)) state_q <= ST_STOP;
               end
            end
         end
      end
   end

   // R6: a start bit that votes high returns the receiver to idle
   a_r6_false_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START && eval && vote) |=> (state_q == ST_IDLE && !done_o));

   // R4: a split vote inside the data bits is remembered for the frame
   a_r4_noise_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && eval && !unan) |=> noise_acc_q);

   // R5: a low stop vote ends the frame with the framing indication
   a_r5_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP && eval && !vote) |=> (done_o && frame_err_o));

   a_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/srx_regs.sv
module srx_regs
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] char_i,
   input  logic              noise_i,
   input  logic              frame_err_i,
   input  logic              stat_rd_i,
   input  logic              data_rd_i,
   output logic [3:0]        status_o,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o
);

   srx_err_t          err_q, err_d, arm_q, arm_d;
   logic [DATA_W-1:0] data_q, data_d;
   logic              full_q, full_d;

   always_comb begin
      err_d  = err_q;
      arm_d  = arm_q;
      data_d = data_q;
      full_d = full_q;
      if (data_rd_i) begin
         err_d  = err_q & ~arm_q;
         arm_d  = '0;
         full_d = 1'b0;
      end
      if (stat_rd_i) arm_d = err_q;
      if (done_i) begin
         if (full_q && !data_rd_i) begin
            err_d.overrun = 1'b1;
         end else begin
            data_d        = char_i;
            full_d        = 1'b1;
            err_d.noise   = err_d.noise | noise_i;
            err_d.framing = err_d.framing | frame_err_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= '0;
         arm_q  <= '0;
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         err_q  <= err_d;
         arm_q  <= arm_d;
         data_q <= data_d;
         full_q <= full_d;
      end
   end

   assign status_o = {full_q, err_q.overrun, err_q.noise, err_q.framing};
   assign data_o   = data_q;
   assign full_o   = full_q;

   // R2: a character arriving into an empty register is loaded and marked full
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !full_q) |=> (full_q && data_q == $past(char_i)));

   // R7: an arrival into a full register keeps the old character and flags overrun
   a_r7_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && full_q && !data_rd_i) |=> (err_q.overrun && $stable(data_q)));

   // R8: an armed overrun is cleared by the data read
   a_r8_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && arm_q.overrun && !done_i) |=> !err_q.overrun);

   // R9: a data read with nothing armed keeps every flag and empties the register
   a_r9_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && !stat_rd_i && arm_q == '0 && !done_i)
      |=> (!full_q && ((err_q & $past(err_q)) == $past(err_q))));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              stat_rd_i,
   input  logic              data_rd_i,
   output logic [3:0]        status_o,
   output logic [DATA_W-1:0] data_o,
   output logic              rx_full_o
);

   generate
      if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_core: OVS must be even and at least 8");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_rx_core: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("serial_rx_core: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              line;
   logic              done;
   logic [DATA_W-1:0] char_w;
   logic              noise_w, ferr_w;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (line)
   );

   srx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .line_i      (line),
      .done_o      (done),
      .char_o      (char_w),
      .noise_o     (noise_w),
      .frame_err_o (ferr_w)
   );

   srx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done),
      .char_i      (char_w),
      .noise_i     (noise_w),
      .frame_err_i (ferr_w),
      .stat_rd_i   (stat_rd_i),
      .data_rd_i   (data_rd_i),
      .status_o    (status_o),
      .data_o      (data_o),
      .full_o      (rx_full_o)
   );

endmodule

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       rxd = 1'b1;
   logic       stat_rd = 1'b0;
   logic       data_rd = 1'b0;
   logic [3:0] status;
   logic [7:0] data;
   logic       full;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   serial_rx_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .rxd_i     (rxd),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .status_o  (status),
      .data_o    (data),
      .rx_full_o (full)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // bits: 0 start, 1..8 data, 9 stop; one sample (bad_bit, bad_pos) inverted
   task automatic send(input logic [7:0] d, input logic stop_v, input int bad_bit, input int bad_pos);
      for (int k = 0; k < 10; k++) begin
         logic v;
         v = (k == 0) ? 1'b0 : (k == 9) ? stop_v : d[k-1];
         for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            rxd = v ^ ((k == bad_bit) && (j == bad_pos));
         end
      end
      @(negedge clk);
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic rd_stat(output logic [3:0] s);
      @(negedge clk);
      s = status;
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic rd_data(output logic [7:0] v);
      @(negedge clk);
      v = data;
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
   endtask

   task automatic clear_all();
      logic [3:0] s;
      logic [7:0] v;
      rd_stat(s);
      rd_data(v);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [3:0] s;
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 status", status, 0);
      chk("R1 data", data, 0);
      chk("R1 full", full, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2: every character value, clean frames
      for (int d = 0; d < 256; d++) begin
         send(8'(d), 1'b1, -1, -1);
         chk("R2 status", status, 4'b1000);
         rd_data(v);
         chk("R2 data", v, d);
         chk("R2 full cleared", full, 0);
      end

      // R3 / R4: walk one inverted sample over data bit 3 (frame bit 4)
      for (int p = 0; p < 16; p++) begin
         send(8'hA5, 1'b1, 4, p);
         chk("R3 value", data, 8'hA5);
         chk("R4 noise", status[1], (p >= 7 && p <= 9) ? 1 : 0);
         clear_all();
         chk("R8 noise cleared", status, 0);
      end

      // R5 framing, R9 plain read keeps it, R8 two-step clears it
      send(8'h3C, 1'b0, -1, -1);
      chk("R5 framing", status, 4'b1001);
      chk("R5 data", data, 8'h3C);
      rd_data(v);
      chk("R9 full cleared", full, 0);
      chk("R9 framing kept", status, 4'b0001);
      clear_all();
      chk("R8 framing cleared", status, 0);

      // R6 false start then a good frame
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         rxd = 1'b0;
      end
      @(negedge clk);
      rxd = 1'b1;
      repeat (200) @(negedge clk);
      chk("R6 no character", full, 0);
      chk("R6 no flags", status, 0);
      send(8'h81, 1'b1, -1, -1);
      chk("R6 next frame", data, 8'h81);
      rd_data(v);

      // R7 overrun
      send(8'h11, 1'b1, -1, -1);
      send(8'h22, 1'b1, -1, -1);
      chk("R7 overrun", status, 4'b1100);
      chk("R7 data kept", data, 8'h11);
      rd_data(v);
      chk("R7 read old", v, 8'h11);
      chk("R9 overrun kept", status, 4'b0100);

      // R10: noise appears after the status read
      rd_stat(s);
      chk("R10 status seen", s, 4'b0100);
      send(8'h66, 1'b1, 2, 8);
      chk("R10 noise set", status, 4'b1110);
      rd_data(v);
      chk("R10 data", v, 8'h66);
      chk("R10 noise kept overrun cleared", status, 4'b0010);
      clear_all();
      chk("R8 all cleared", status, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule